// File: doc/BRIEF.md
# Accumulator ALU with Program Status Word

This block is the 8-bit arithmetic unit of a small microcontroller core. It holds the accumulator and the program status word. Each cycle it can run one operation that combines the accumulator with an operand and stores the result back into the accumulator. Hardware updates the carry, auxiliary-carry and overflow flags after arithmetic. Parity always follows the accumulator. The status word has no negative flag and no zero flag. Branch logic instead reads a zero indication and the accumulator's top bit from two dedicated outputs.

Software reaches the accumulator and the status word as special-function registers. A write to either register replaces its whole contents. Three other parts of the status word change only on a software write: the two register-bank select bits, a general flag at bit 5 and a user flag at bit 1. The bank select bits are also driven out to the register-file addressing logic.

Top module: `acc_alu_psw`

## Requirements
- R1: After reset the accumulator reads 0x00, the status word reads 0x00 and the bank select output is 0.
- R2: Opcode 0 (add) loads A+B into the accumulator and opcode 1 (add with carry) loads A+B+C. In both, C becomes the carry out of bit 7.
- R3: Add, add-with-carry and subtract-with-borrow set OV (status bit 2) exactly when the two's-complement result is out of range, and clear it otherwise.
- R4: Additions set AC (status bit 6) on a carry out of bit 3. Subtract-with-borrow sets AC on a borrow out of bit 3.
- R5: Opcode 2 (subtract with borrow) loads A-B-C modulo 256 and sets C when the true difference is negative.
- R6: Opcodes 3, 4 and 5 load A AND B, A OR B and A XOR B. C, AC and OV keep their values.
- R7: Status bit 0 always equals the XOR of all accumulator bits. A software write to bit 0 has no effect.
- R8: Bit 5 (general flag), bit 1 (user flag) and bits 4:3 (bank select, bit 4 high) change only on a status-word write. The bank select output equals bits 4:3.
- R9: If a status-word write and an arithmetic flag update occur in the same cycle, status bits 7:1 take the written value.
- R10: The zero output is high exactly when the accumulator is 0x00. The sign output equals accumulator bit 7.
- R11: Opcode 6 copies the operand into the accumulator and leaves C, AC and OV unchanged. Opcode 7 changes neither the accumulator nor any status bit.
- R12: A direct accumulator write takes priority over an operation in the same cycle. The operation is discarded and C, AC and OV keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Run the operation on opCode this cycle |
| opCode | input | 3 | Operation select (0 add, 1 add-carry, 2 sub-borrow, 3 and, 4 or, 5 xor, 6 move, 7 none) |
| operand | input | 8 | Second operand B |
| accWrEn | input | 1 | Direct accumulator write strobe |
| accWrData | input | 8 | Direct accumulator write value |
| pswWrEn | input | 1 | Status-word write strobe |
| pswWrData | input | 8 | Status-word write value |
| accOut | output | 8 | Current accumulator |
| pswRdData | output | 8 | Current status word |
| accZero | output | 1 | Accumulator equals zero |
| accSign | output | 1 | Accumulator bit 7 |
| bankSel | output | 2 | Register bank select |

## Verification
The assertions check several properties on every cycle: parity against the accumulator, the zero and sign outputs, the stability of the software-only bits, and the precedence of status-word and accumulator writes. They also check that logical operations leave the carry flags alone, that the no-operation code is inert, and that the add overflow rule holds. The exact arithmetic values can only be shown by the bench, which compares every cycle against a reference model. That covers the carry, borrow and nibble-carry results of add-with-carry and subtract-with-borrow, wrap to zero, and the signed overflow corners at 0x7F/0x80.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int PSW_C   = 7;
  localparam int PSW_AC  = 6;
  localparam int PSW_F0  = 5;
  localparam int PSW_RS1 = 4;
  localparam int PSW_RS0 = 3;
  localparam int PSW_OV  = 2;
  localparam int PSW_UD  = 1;
  localparam int PSW_P   = 0;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDC = 3'd1,
    OP_SUBB = 3'd2,
    OP_AND  = 3'd3,
    OP_OR   = 3'd4,
    OP_XOR  = 3'd5,
    OP_MOV  = 3'd6,
    OP_NOP  = 3'd7
  } aluOp_e;

  typedef enum logic [1:0] {
    LG_AND  = 2'd0,
    LG_OR   = 2'd1,
    LG_XOR  = 2'd2,
    LG_PASS = 2'd3
  } logicSel_e;

  typedef struct packed {
    logic      accLoad;
    logic      accFromBus;
    logic      arith;
    logic      useCarry;
    logic      subtract;
    logicSel_e logicSel;
    logic      flagLoad;
    logic      pswLoad;
  } ctrlStrobe_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  input  logic              subtract,
  output logic [DATA_W-1:0] sumOut,
  output logic              carryOut,
  output logic              auxOut,
  output logic              ovOut
);
  localparam int NIB_W = DATA_W / 2;

  logic [DATA_W-1:0] bEff;
  logic              cinEff;
  logic [DATA_W:0]   fullSum;
  logic [NIB_W:0]    lowSum;

  always_comb begin
    bEff     = subtract ? ~opB : opB;
    cinEff   = subtract ? ~carryIn : carryIn;
    fullSum  = {1'b0, opA} + {1'b0, bEff} + {{DATA_W{1'b0}}, cinEff};
    lowSum   = {1'b0, opA[NIB_W-1:0]} + {1'b0, bEff[NIB_W-1:0]} + {{NIB_W{1'b0}}, cinEff};
    sumOut   = fullSum[DATA_W-1:0];
    carryOut = fullSum[DATA_W] ^ subtract;
    auxOut   = lowSum[NIB_W] ^ subtract;
    ovOut    = (opA[DATA_W-1] == bEff[DATA_W-1]) && (sumOut[DATA_W-1] != opA[DATA_W-1]);
  end
endmodule

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic        opValid,
  input  logic [2:0]  opCode,
  input  logic        accWrEn,
  input  logic        pswWrEn,
  output ctrlStrobe_t strobe
);
  always_comb begin
    strobe          = '0;
    strobe.logicSel = LG_PASS;
    strobe.pswLoad  = pswWrEn;
    if (accWrEn) begin
      strobe.accLoad    = 1'b1;
      strobe.accFromBus = 1'b1;
    end else if (opValid) begin
      unique case (aluOp_e'(opCode))
        OP_ADD: begin
          strobe.accLoad  = 1'b1;
          strobe.arith    = 1'b1;
          strobe.flagLoad = 1'b1;
        end
        OP_ADDC: begin
          strobe.accLoad  = 1'b1;
          strobe.arith    = 1'b1;
          strobe.useCarry = 1'b1;
          strobe.flagLoad = 1'b1;
        end
        OP_SUBB: begin
          strobe.accLoad  = 1'b1;
          strobe.arith    = 1'b1;
          strobe.useCarry = 1'b1;
          strobe.subtract = 1'b1;
          strobe.flagLoad = 1'b1;
        end
        OP_AND: begin
          strobe.accLoad  = 1'b1;
          strobe.logicSel = LG_AND;
        end
        OP_OR: begin
          strobe.accLoad  = 1'b1;
          strobe.logicSel = LG_OR;
        end
        OP_XOR: begin
          strobe.accLoad  = 1'b1;
          strobe.logicSel = LG_XOR;
        end
        OP_MOV: begin
          strobe.accLoad  = 1'b1;
          strobe.logicSel = LG_PASS;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/alu_dpath.sv
module alu_dpath
  import alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] accWrData,
  input  logic [7:0]        pswWrData,
  output logic [DATA_W-1:0] accQ,
  output logic [7:0]        pswQ
);
  logic              cFlag, acFlag, ovFlag, f0Flag, udFlag;
  logic [1:0]        bankQ;
  logic [DATA_W-1:0] sumRes, logicRes, accNext;
  logic              sumC, sumAc, sumOv;
  logic              unusedPswBit;

  assign unusedPswBit = pswWrData[PSW_P];

  alu_addsub #(.DATA_W(DATA_W)) addsub_i (
    .opA     (accQ),
    .opB     (operand),
    .carryIn (strobe.useCarry & cFlag),
    .subtract(strobe.subtract),
    .sumOut  (sumRes),
    .carryOut(sumC),
    .auxOut  (sumAc),
    .ovOut   (sumOv)
  );

  always_comb begin
    unique case (strobe.logicSel)
      LG_AND:  logicRes = accQ & operand;
      LG_OR:   logicRes = accQ | operand;
      LG_XOR:  logicRes = accQ ^ operand;
      default: logicRes = operand;
    endcase
    if (strobe.accFromBus)  accNext = accWrData;
    else if (strobe.arith)  accNext = sumRes;
    else                    accNext = logicRes;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ <= '0;
    end else if (strobe.accLoad) begin
      accQ <= accNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cFlag  <= 1'b0;
      acFlag <= 1'b0;
      ovFlag <= 1'b0;
    end else if (strobe.pswLoad) begin
      cFlag  <= pswWrData[PSW_C];
      acFlag <= pswWrData[PSW_AC];
      ovFlag <= pswWrData[PSW_OV];
    end else if (strobe.flagLoad) begin
      cFlag  <= sumC;
      acFlag <= sumAc;
      ovFlag <= sumOv;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      f0Flag <= 1'b0;
      udFlag <= 1'b0;
      bankQ  <= 2'b00;
    end else if (strobe.pswLoad) begin
      f0Flag <= pswWrData[PSW_F0];
      udFlag <= pswWrData[PSW_UD];
      bankQ  <= pswWrData[PSW_RS1:PSW_RS0];
    end
  end

  always_comb begin
    pswQ                  = '0;
    pswQ[PSW_C]           = cFlag;
    pswQ[PSW_AC]          = acFlag;
    pswQ[PSW_F0]          = f0Flag;
    pswQ[PSW_RS1:PSW_RS0] = bankQ;
    pswQ[PSW_OV]          = ovFlag;
    pswQ[PSW_UD]          = udFlag;
    pswQ[PSW_P]           = ^accQ;
  end
endmodule

// File: rtl/acc_alu_psw.sv
module acc_alu_psw
  import alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [DATA_W-1:0] operand,
  input  logic              accWrEn,
  input  logic [DATA_W-1:0] accWrData,
  input  logic              pswWrEn,
  input  logic [7:0]        pswWrData,
  output logic [DATA_W-1:0] accOut,
  output logic [7:0]        pswRdData,
  output logic              accZero,
  output logic              accSign,
  output logic [1:0]        bankSel
);
  ctrlStrobe_t strobe;

  alu_ctrl ctrl_i (
    .opValid(opValid),
    .opCode (opCode),
    .accWrEn(accWrEn),
    .pswWrEn(pswWrEn),
    .strobe (strobe)
  );

  alu_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .operand  (operand),
    .accWrData(accWrData),
    .pswWrData(pswWrData),
    .accQ     (accOut),
    .pswQ     (pswRdData)
  );

  assign accZero = (accOut == '0);
  assign accSign = accOut[DATA_W-1];
  assign bankSel = pswRdData[PSW_RS1:PSW_RS0];
endmodule

// File: rtl/acc_alu_psw_chk.sv
module acc_alu_psw_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [2:0]        opCode,
  input logic [DATA_W-1:0] operand,
  input logic              accWrEn,
  input logic [DATA_W-1:0] accWrData,
  input logic              pswWrEn,
  input logic [7:0]        pswWrData,
  input logic [DATA_W-1:0] accOut,
  input logic [7:0]        pswRdData,
  input logic              accZero,
  input logic              accSign,
  input logic [1:0]        bankSel
);
  logic plainOp;
  assign plainOp = opValid && !accWrEn && !pswWrEn;

  p_parity_r7: assert property (@(posedge clk) disable iff (!rstN)
    pswRdData[0] == ^accOut);

  p_zero_sign_r10: assert property (@(posedge clk) disable iff (!rstN)
    (accZero == (accOut == '0)) && (accSign == accOut[DATA_W-1]));

  p_bank_out_r8: assert property (@(posedge clk) disable iff (!rstN)
    bankSel == pswRdData[4:3]);

  p_soft_bits_r8: assert property (@(posedge clk) disable iff (!rstN)
    !pswWrEn |=> $stable({pswRdData[5:3], pswRdData[1]}));

  p_psw_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    pswWrEn |=> pswRdData[7:1] == $past(pswWrData[7:1]));

  p_logic_keeps_r6: assert property (@(posedge clk) disable iff (!rstN)
    plainOp && (opCode inside {3'd3, 3'd4, 3'd5, 3'd6}) |=>
      $stable({pswRdData[7:6], pswRdData[2]}));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    plainOp && opCode == 3'd0 |=>
      pswRdData[2] == (($past(accOut[DATA_W-1]) == $past(operand[DATA_W-1])) &&
                       (accOut[DATA_W-1] != $past(accOut[DATA_W-1]))));

  p_nop_inert_r11: assert property (@(posedge clk) disable iff (!rstN)
    plainOp && opCode == 3'd7 |=> $stable(accOut) && $stable(pswRdData));

  p_acc_write_r12: assert property (@(posedge clk) disable iff (!rstN)
    accWrEn |=> accOut == $past(accWrData));

  p_acc_write_flags_r12: assert property (@(posedge clk) disable iff (!rstN)
    accWrEn && !pswWrEn |=> $stable({pswRdData[7:6], pswRdData[2]}));
endmodule

bind acc_alu_psw acc_alu_psw_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/acc_alu_psw_tb_top.sv
module acc_alu_psw_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [2:0] opCode = 3'd0;
  logic [7:0] operand = 8'h00;
  logic       accWrEn = 1'b0;
  logic [7:0] accWrData = 8'h00;
  logic       pswWrEn = 1'b0;
  logic [7:0] pswWrData = 8'h00;
  logic [7:0] accOut, pswRdData;
  logic       accZero, accSign;
  logic [1:0] bankSel;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  int mAcc = 0, mC = 0, mAc = 0, mOv = 0, mF0 = 0, mRs = 0, mUd = 0;

  always #2 clk = ~clk;

  acc_alu_psw dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .operand(operand),
    .accWrEn(accWrEn), .accWrData(accWrData), .pswWrEn(pswWrEn), .pswWrData(pswWrData),
    .accOut(accOut), .pswRdData(pswRdData), .accZero(accZero), .accSign(accSign),
    .bankSel(bankSel)
  );

  function automatic int sgn(int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  function automatic int par(int v);
    int p = 0;
    for (int i = 0; i < 8; i++) p ^= (v >> i) & 1;
    return p;
  endfunction

  function automatic int expPsw();
    return (mC << 7) | (mAc << 6) | (mF0 << 5) | (mRs << 3) | (mOv << 2) | (mUd << 1) | par(mAcc);
  endfunction

  task automatic modelStep();
    int a = mAcc, b = int'(operand), r, ci;
    if (accWrEn) mAcc = int'(accWrData);
    else if (opValid) begin
      case (int'(opCode))
        0, 1: begin
          ci = (opCode == 3'd1) ? mC : 0;
          r = a + b + ci;
          mAcc = r % 256; mC = (r > 255);
          mAc = ((a % 16) + (b % 16) + ci) > 15;
          r = sgn(a) + sgn(b) + ci; mOv = (r > 127 || r < -128);
        end
        2: begin
          ci = mC;
          r = a - b - ci;
          mAcc = (r + 256) % 256; mC = (r < 0);
          mAc = ((a % 16) - (b % 16) - ci) < 0;
          r = sgn(a) - sgn(b) - ci; mOv = (r > 127 || r < -128);
        end
        3: mAcc = a & b;
        4: mAcc = a | b;
        5: mAcc = a ^ b;
        6: mAcc = b;
        default: ;
      endcase
    end
    if (pswWrEn) begin
      mC  = (int'(pswWrData) >> 7) & 1;
      mAc = (int'(pswWrData) >> 6) & 1;
      mF0 = (int'(pswWrData) >> 5) & 1;
      mRs = (int'(pswWrData) >> 3) & 3;
      mOv = (int'(pswWrData) >> 2) & 1;
      mUd = (int'(pswWrData) >> 1) & 1;
    end
  endtask

  task automatic compare(string tag);
    int ep = expPsw();
    tests++;
    if (int'(accOut) != mAcc || int'(pswRdData) != ep || accZero != (mAcc == 0) ||
        accSign != ((mAcc >> 7) & 1) || int'(bankSel) != mRs) begin
      fails++;
      $display("FAIL %s acc=%02h psw=%02h z=%0d s=%0d bank=%0d expected acc=%02h psw=%02h z=%0d s=%0d bank=%0d",
               tag, accOut, pswRdData, accZero, accSign, bankSel,
               mAcc, ep, (mAcc == 0), (mAcc >> 7) & 1, mRs);
    end
  endtask

  task automatic cyc(string tag, bit v, int op, int b, bit aw = 0, int ad = 0, bit pw = 0, int pd = 0);
    opValid = v; opCode = op[2:0]; operand = b[7:0];
    accWrEn = aw; accWrData = ad[7:0]; pswWrEn = pw; pswWrData = pd[7:0];
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compare(tag);
    opValid = 0; accWrEn = 0; pswWrEn = 0;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    compare("R1 reset state");
    rstN = 1'b1;
    @(negedge clk);
    compare("R1 after release");

    cyc("R11 move", 1, 6, 'h3A);
    cyc("R3 R4 add overflow aux", 1, 0, 'h47);
    cyc("R10 R12 acc write", 0, 0, 0, 1, 'hFF);
    cyc("R2 R10 add wrap zero", 1, 0, 'h01);
    cyc("R2 addc with carry", 1, 1, 'h10);
    cyc("R5 R4 subb borrow", 1, 2, 'h20);
    cyc("R5 subb uses carry", 1, 2, 'h01);
    cyc("R12 acc write", 0, 0, 0, 1, 'h80);
    cyc("R10 sign high", 0, 7, 0);
    cyc("R3 subb signed overflow", 1, 2, 'h7F);
    cyc("R12 acc 7F", 0, 0, 0, 1, 'h7F);
    cyc("R3 add 7F+1", 1, 0, 'h01);
    cyc("R6 and", 1, 3, 'h0F);
    cyc("R6 or", 1, 4, 'hA5);
    cyc("R6 xor", 1, 5, 'h3C);
    cyc("R8 R7 psw write all", 0, 0, 0, 0, 0, 1, 'hFF);
    cyc("R8 R11 nop keeps", 1, 7, 'h55);
    cyc("R8 R7 psw write clear", 0, 0, 0, 0, 0, 1, 'h01);
    cyc("R8 bank 2", 0, 0, 0, 0, 0, 1, 'h10);
    cyc("R9 write beats add", 1, 0, 'hFF, 0, 0, 1, 'h28);
    cyc("R9 write beats subb", 1, 2, 'h01, 0, 0, 1, 'hC4);
    cyc("R12 acc write beats add", 1, 0, 'h99, 1, 'h11);
    cyc("R11 move zero", 1, 6, 'h00);

    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      bit aw, pw;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      aw = (lfsr[11:9] == 3'd0);
      pw = (lfsr[14:12] == 3'd1);
      cyc("R2 R3 R4 R5 R6 random", lfsr[15], int'(lfsr[2:0]), int'(lfsr[10:3]),
          aw, int'(lfsr[7:0]), pw, int'({lfsr[4:0], lfsr[15:13]}));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule